// File: doc/BRIEF.md
# Quadrature Edge-Pulse Decoder Built From Lookup-Table Cells

This block turns the two phase signals of an incremental encoder into single-direction step pulses. Each valid edge on either phase produces one pulse. Clockwise motion drives one output and counter-clockwise motion drives the other, so a full encoder cycle yields four pulses (times-four decoding). A counter downstream can then add the two pulse streams, or subtract one from the other, to track position.

The decode is not done by a fixed state machine. The two phases first pass through a two-flop synchronizer. They then feed four identical logic cells. Each cell looks up one bit of a 16-bit table word, indexed by the same four signals: phase A, phase B, and the outputs of cells 0 and 1. The table index is A + 2·B + 4·cell0 + 8·cell1, and bit k of a word is the result for index k.

Each cell output passes through a filter with its own rise delay and fall delay, counted in clock cycles. Cells 0 and 1 pass A and B through long filters, so their outputs are late copies of the phases. Cells 2 and 3 compare the live phases with those late copies. Each of them goes high for the gap between a phase edge and the moment its copy catches up, which makes the short direction pulse. The table words and all delays are configuration inputs.

Top module: `qenc_lut_decoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, both pulse outputs are 0. With idle phases no pulse appears.
- R2: With the default tables (cell0 0xAAAA, cell1 0xCCCC, cell2 0x4182, cell3 0x2814), `cw_pulse` gives exactly one pulse for each of these edges: A rising while B is low, B rising while A is high, A falling while B is high, B falling while A is low.
- R3: With the default tables, `ccw_pulse` gives exactly one pulse for each of these edges: B rising while A is low, A rising while B is high, B falling while A is high, A falling while B is low. This holds also right after a change of direction.
- R4: A pulse lasts 1 + Dc + Fk − Rk cycles. Dc is the copy cell's rise delay for a rising phase edge, or its fall delay for a falling one. Rk and Fk are the rise and fall delays of the output cell (cell 2 for `cw_pulse`, cell 3 for `ccw_pulse`).
- R5: A pulse is first seen high 3 + Rk rising clock edges after a phase input changes. This is two synchronizer stages plus one filter register plus Rk cycles of filter wait.
- R6: A cell output rises only after its table result has been 1 for Rk+1 consecutive cycles. A phase glitch too short for that produces no pulse.
- R7: The table words set the decode. Swapping the words of cell 2 and cell 3 swaps which output pulses for a given direction.
- R8: A delay of 0 makes the output follow its table result one cycle later. With cell 2 rise delay 0 and fall delay 3, a clockwise edge gives a 9-cycle pulse that starts 3 edges after the input change.
- R9: If A and B change in the same cycle, no pulse is produced on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all filter delays count its cycles |
| rst | input | 1 | Synchronous active-high reset; clears the synchronizer, filters and outputs |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| cfg_lut | input | 64 | Table words; cell k uses bits [16k+15:16k] |
| cfg_rise | input | 16 | Rise delays, DLY_W bits per cell; cell k uses bits [DLY_W·k+DLY_W−1:DLY_W·k] |
| cfg_fall | input | 16 | Fall delays, same packing as cfg_rise |
| cw_pulse | output | 1 | Clockwise step pulse (registered output of cell 2) |
| ccw_pulse | output | 1 | Counter-clockwise step pulse (registered output of cell 3) |

## Verification
The bench drives every one of the eight valid edge types, including a change of direction part way through a cycle. For each edge it predicts the output pin, the pulse width and the start cycle, so it catches a mis-indexed table bit (pulse on the wrong pin, or a missing pulse) and a filter that is off by one (a pulse one cycle too wide or too late).

A two-cycle glitch on each phase checks that a filter which counted too few cycles would leak a false step. A simultaneous change of A and B checks that a decoder treating any change as motion would count an illegal jump.

A zero rise delay combined with a longer fall delay checks that the two delays are not mixed up. A design that swapped them would give a 3-cycle pulse instead of a 9-cycle one. The table swap confirms that direction comes from the table words and not from fixed logic.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int NUM_CELLS = 4;
  localparam int SEL_W     = 4;
  localparam int LUT_W     = 1 << SEL_W;
  localparam int CELL_CPA  = 0;
  localparam int CELL_CPB  = 1;
  localparam int CELL_CW   = 2;
  localparam int CELL_CCW  = 3;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_r [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_r[0] <= '0;
    else     stage_r[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_r[s] <= '0;
        else     stage_r[s] <= stage_r[s-1];
      end
    end
  endgenerate

  assign q = stage_r[STAGES-1];
endmodule

// File: rtl/qenc_cell.sv
module qenc_cell #(
  parameter int SEL_W = 4,
  parameter int DLY_W = 4,
  localparam int LUT_W = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic [LUT_W-1:0] lut,
  input  logic [DLY_W-1:0] rise_dly,
  input  logic [DLY_W-1:0] fall_dly,
  output logic             q
);
  logic             raw;
  logic [DLY_W-1:0] limit;
  logic [DLY_W-1:0] wait_cnt;

  assign raw = lut[sel];

  always_comb limit = raw ? rise_dly : fall_dly;

  // A new level is accepted once it has held for limit+1 samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      q        <= 1'b0;
      wait_cnt <= '0;
    end else if (raw == q) begin
      wait_cnt <= '0;
    end else if (wait_cnt >= limit) begin
      q        <= raw;
      wait_cnt <= '0;
    end else begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/qenc_lut_decoder.sv
module qenc_lut_decoder
  import qenc_pkg::*;
#(
  parameter int DLY_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       enc_a,
  input  logic                       enc_b,
  input  logic [NUM_CELLS*LUT_W-1:0] cfg_lut,
  input  logic [NUM_CELLS*DLY_W-1:0] cfg_rise,
  input  logic [NUM_CELLS*DLY_W-1:0] cfg_fall,
  output logic                       cw_pulse,
  output logic                       ccw_pulse
);
  logic [1:0]           enc_s;
  logic [NUM_CELLS-1:0] cell_q;
  logic [SEL_W-1:0]     cell_idx;

  qenc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({enc_b, enc_a}),
    .q   (enc_s)
  );

  // Index bit order: I0 = A, I1 = B, I2 = copy of A, I3 = copy of B.
  assign cell_idx = {cell_q[CELL_CPB], cell_q[CELL_CPA], enc_s[1], enc_s[0]};

  generate
    for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cell
      qenc_cell #(.SEL_W(SEL_W), .DLY_W(DLY_W)) u_cell (
        .clk      (clk),
        .rst      (rst),
        .sel      (cell_idx),
        .lut      (cfg_lut[k*LUT_W +: LUT_W]),
        .rise_dly (cfg_rise[k*DLY_W +: DLY_W]),
        .fall_dly (cfg_fall[k*DLY_W +: DLY_W]),
        .q        (cell_q[k])
      );
    end
  endgenerate

  assign cw_pulse  = cell_q[CELL_CW];
  assign ccw_pulse = cell_q[CELL_CCW];
endmodule

// File: rtl/qenc_lut_decoder_chk.sv
module qenc_lut_decoder_chk #(
  parameter int DLY_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cw_pulse,
  input logic             ccw_pulse,
  input logic [3:0]       cell_idx,
  input logic [15:0]      lut_cw,
  input logic [DLY_W-1:0] rise_cw,
  input logic [DLY_W-1:0] fall_cw
);
  logic           raw_cw;
  logic [DLY_W:0] hi_run;
  logic [DLY_W:0] lo_run;

  assign raw_cw = lut_cw[cell_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= raw_cw  ? ((&hi_run) ? hi_run : hi_run + 1'b1) : '0;
      lo_run <= !raw_cw ? ((&lo_run) ? lo_run : lo_run + 1'b1) : '0;
    end
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) rst |=> (!cw_pulse && !ccw_pulse)); // R1
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst) !(cw_pulse && ccw_pulse)); // R2
  AST_RISE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst) $rose(cw_pulse) |-> ($past(hi_run) >= {1'b0, $past(rise_cw)})); // R6
  AST_FALL_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst) $fell(cw_pulse) |-> ($past(lo_run) >= {1'b0, $past(fall_cw)})); // R4
  AST_ZERO_DELAY_FOLLOW: assert property (@(posedge clk) disable iff (rst) (rise_cw == '0 && fall_cw == '0) |=> (cw_pulse == $past(raw_cw))); // R8
endmodule

bind qenc_lut_decoder qenc_lut_decoder_chk #(.DLY_W(DLY_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cw_pulse  (cw_pulse),
  .ccw_pulse (ccw_pulse),
  .cell_idx  (cell_idx),
  .lut_cw    (cfg_lut[qenc_pkg::CELL_CW*qenc_pkg::LUT_W +: qenc_pkg::LUT_W]),
  .rise_cw   (cfg_rise[qenc_pkg::CELL_CW*DLY_W +: DLY_W]),
  .fall_cw   (cfg_fall[qenc_pkg::CELL_CW*DLY_W +: DLY_W])
);

// File: tb/qenc_lut_decoder_tb.sv
module qenc_lut_decoder_tb;
  localparam int DLY_W = 4;
  localparam int GAP   = 28;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_a = 1'b0;
  logic        enc_b = 1'b0;
  logic [63:0] cfg_lut;
  logic [15:0] cfg_rise;
  logic [15:0] cfg_fall;
  logic        cw_pulse;
  logic        ccw_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;
  int swap = 0;
  bit done = 0;
  int rise_b [4];
  int fall_b [4];
  logic [15:0] lut_b [4];

  int    q_dir[$];
  int    q_w[$];
  int    q_start[$];
  string q_req[$];

  bit in_p = 0;
  int p_dir, p_w, p_start;

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  qenc_lut_decoder #(.DLY_W(DLY_W)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .enc_a     (enc_a),
    .enc_b     (enc_b),
    .cfg_lut   (cfg_lut),
    .cfg_rise  (cfg_rise),
    .cfg_fall  (cfg_fall),
    .cw_pulse  (cw_pulse),
    .ccw_pulse (ccw_pulse)
  );

  task automatic apply_cfg();
    for (int k = 0; k < 4; k++) begin
      cfg_lut[k*16 +: 16]       = lut_b[k];
      cfg_rise[k*DLY_W +: DLY_W] = DLY_W'(rise_b[k]);
      cfg_fall[k*DLY_W +: DLY_W] = DLY_W'(fall_b[k]);
    end
  endtask

  // 0 = clockwise, 1 = counter-clockwise, -1 = no step
  function automatic int dir_of(logic oa, logic ob, logic na, logic nb);
    if (na != oa && nb != ob) return -1;
    if (na != oa) begin
      if (na) return ob ? 1 : 0;
      else    return ob ? 0 : 1;
    end
    if (nb != ob) begin
      if (nb) return oa ? 0 : 1;
      else    return oa ? 1 : 0;
    end
    return -1;
  endfunction

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // Driver: changes the phases and pushes the predicted pulse.
  task automatic step(input logic na, input logic nb, input string req);
    int d, pin, k, dcopy;
    @(negedge clk);
    d = dir_of(enc_a, enc_b, na, nb);
    if (d >= 0) begin
      pin = d ^ swap;
      k = 2 + pin;
      if (na != enc_a) dcopy = na ? rise_b[0] : fall_b[0];
      else             dcopy = nb ? rise_b[1] : fall_b[1];
      q_dir.push_back(pin);
      q_w.push_back(1 + dcopy + fall_b[k] - rise_b[k]);
      q_start.push_back(cyc + 3 + rise_b[k]);
      q_req.push_back(req);
    end
    enc_a = na;
    enc_b = nb;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic glitch(input bit on_b, input int len, input string req);
    int n0;
    n0 = pulses;
    @(negedge clk);
    if (on_b) enc_b = ~enc_b; else enc_a = ~enc_a;
    repeat (len) @(negedge clk);
    if (on_b) enc_b = ~enc_b; else enc_a = ~enc_a;
    repeat (GAP) @(negedge clk);
    check(req, pulses - n0, 0);
  endtask

  // Monitor: measures each pulse and compares it with the queue head.
  always @(negedge clk) begin
    if (rst) begin
      in_p = 0;
    end else if (!in_p && (cw_pulse || ccw_pulse)) begin
      in_p = 1;
      p_dir = ccw_pulse ? 1 : 0;
      p_start = cyc;
      p_w = 1;
      pulses++;
    end else if (in_p && (cw_pulse || ccw_pulse)) begin
      p_w++;
    end else if (in_p) begin
      in_p = 0;
      checks++;
      if (q_dir.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected pulse pin=%0d actual=%0d expected=none", p_dir, p_w);
      end else begin
        automatic int    ed = q_dir.pop_front();
        automatic int    ew = q_w.pop_front();
        automatic int    es = q_start.pop_front();
        automatic string er = q_req.pop_front();
        if (ed != p_dir || ew != p_w || es != p_start) begin
          errors++;
          $display("FAIL %s actual pin/width/start=%0d/%0d/%0d expected=%0d/%0d/%0d",
                   er, p_dir, p_w, p_start, ed, ew, es);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    lut_b[0] = 16'hAAAA; lut_b[1] = 16'hCCCC; lut_b[2] = 16'h4182; lut_b[3] = 16'h2814;
    rise_b[0] = 5; fall_b[0] = 5; rise_b[1] = 5; fall_b[1] = 5;
    rise_b[2] = 2; fall_b[2] = 2; rise_b[3] = 2; fall_b[3] = 2;
    apply_cfg();
    repeat (5) @(negedge clk);
    check("R1 cw in reset", int'(cw_pulse), 0);
    check("R1 ccw in reset", int'(ccw_pulse), 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check("R1 idle pulses", pulses, 0);

    // R2 clockwise, two full cycles; R4 R5 width and start in the scoreboard
    for (int i = 0; i < 2; i++) begin
      step(1, 0, "R2 R4 R5 A up B low");
      step(1, 1, "R2 R4 R5 B up A high");
      step(0, 1, "R2 R4 R5 A down B high");
      step(0, 0, "R2 R4 R5 B down A low");
    end
    // R3 counter-clockwise, two full cycles
    for (int i = 0; i < 2; i++) begin
      step(0, 1, "R3 B up A low");
      step(1, 1, "R3 A up B high");
      step(1, 0, "R3 B down A high");
      step(0, 0, "R3 A down B low");
    end
    // R3 reversal in mid-cycle
    step(1, 0, "R2 before reversal");
    step(1, 1, "R2 before reversal");
    step(1, 0, "R3 after reversal");
    step(0, 0, "R3 after reversal");

    // R6 short glitches on each phase
    glitch(0, 2, "R6 glitch on A");
    glitch(1, 2, "R6 glitch on B");

    // R9 both phases change together
    begin
      int n0;
      n0 = pulses;
      step(1, 1, "R9 simultaneous");
      step(0, 0, "R9 simultaneous");
      check("R9 no pulse on joint change", pulses - n0, 0);
    end

    // R8 zero rise delay on the clockwise cell
    rise_b[2] = 0; fall_b[2] = 3;
    apply_cfg();
    step(1, 0, "R8 zero rise delay");
    step(1, 1, "R8 zero rise delay");
    rise_b[2] = 2; fall_b[2] = 2;
    apply_cfg();
    step(0, 1, "R2 after restore");
    step(0, 0, "R2 after restore");

    // R7 swapped table words
    lut_b[2] = 16'h2814; lut_b[3] = 16'h4182; swap = 1;
    apply_cfg();
    step(1, 0, "R7 swapped tables");
    step(1, 1, "R7 swapped tables");
    step(0, 1, "R7 swapped tables");
    step(0, 0, "R7 swapped tables");

    repeat (GAP) @(negedge clk);
    check("R2 all predicted pulses seen", q_dir.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule